// File: doc/BRIEF.md
# Byte-Block Bit-Plane Transposer with Character Classes

This block takes a block of `W` bytes and turns it into eight basis bit streams. Plane `b` collects bit `b` of every byte in the block, one bit per byte position. The same planes then feed a set of `NCLS` character-class streams, built only from bitwise logic on those planes. Bit `j` of a class stream says whether byte `j` of the block belongs to that class. A downstream bit-parallel matcher can then advance markers through whole blocks at once, without looking at bytes one at a time.

Each class is fixed by parameters when the block is configured. A class holds `NRNG` inclusive byte ranges, and a single character is written as a range whose low and high bounds are equal. A class also carries a flag that complements it and a flag that makes it a "match anything on the line" class. Blocks enter through a valid/ready handshake. The planes and class streams leave together in one registered output word, one cycle after the block is accepted. When the consumer stalls, the block stops taking input.

Top module: `byteplane_classifier`

## Requirements
- R1: Byte `j` arrives on `in_data[8j+7:8j]`, and byte 0 is the first byte of the block. Output bit `out_planes[b*W+j]` equals bit `b` of byte `j`, for every plane `b` in 0..7.
- R2: For a class with neither flag set, bit `out_class[c*W+j]` is 1 exactly when byte `j` satisfies lo ≤ byte ≤ hi for at least one of the class's ranges. A range with lo = hi matches that single byte, and a range with lo > hi matches nothing. In the default setup, class 0 is the digits 0x30..0x39 plus 0x5F, and class 1 is 0x41..0x5A plus 0x61..0x7A.
- R3: A class with its complement flag set yields the bitwise inverse of its range membership. In the default setup, class 2 is 1 for every byte outside 0x30..0x39.
- R4: A class with its any-character flag set is 1 for every byte except the newline 0x0A. Its ranges and complement flag have no effect. In the default setup, this is class 3.
- R5: A block accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_planes` and `out_class` after that edge, with `out_valid` high. The latency is exactly one cycle.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid`, `out_planes` and `out_class` hold their values.
- R7: When the held output is taken on an edge where no new block is accepted, `out_valid` is low after that edge.
- R8: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block is valid |
| in_ready | output | 1 | Block can accept an input |
| in_data | input | W*8 | Byte block, byte 0 in the low bits |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_planes | output | 8*W | Basis planes, plane b at bits b*W +: W |
| out_class | output | NCLS*W | Class streams, class c at bits c*W +: W |

## Verification
The embedded assertions check the handshake on every cycle: the one-cycle path from an accepted block to `out_valid`, the hold of the output word under backpressure, and the drop of `out_valid` once the word is taken. They also check, on every valid output, two things. Lane 0 of the planes must match the byte that was accepted. Every lane of the any-character class must agree with the newline test applied to the registered planes. Range, single-character, empty-range and complement membership are checked only by the bench scenarios. These scenarios sweep all 256 byte values through every class, feed random blocks rich in newlines, and set up a stall whose later blocks must not leak through.

// File: rtl/bp_pkg.sv
package bp_pkg;
   localparam int NPLANE = 8;
   localparam logic [7:0] NEWLINE = 8'h0A;
   typedef logic [7:0] byte_t;
endpackage

// File: rtl/bp_transpose.sv
module bp_transpose
   import bp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W*NPLANE-1:0] blk,
   output logic [NPLANE*W-1:0] planes
);
   if (W < 1) begin : g_bad_w
      $error("bp_transpose: W must be at least 1");
   end

   for (genvar j = 0; j < W; j++) begin : g_lane
      for (genvar b = 0; b < NPLANE; b++) begin : g_bit
         assign planes[b*W+j] = blk[j*NPLANE+b];
      end
   end
endmodule

// File: rtl/bp_range_match.sv
module bp_range_match
   import bp_pkg::*;
#(
   parameter int         W  = 16,
   parameter logic [7:0] LO = 8'h00,
   parameter logic [7:0] HI = 8'hFF
) (
   input  logic [NPLANE*W-1:0] planes,
   output logic [W-1:0]        hit
);
   logic [W-1:0] ge_gt, ge_eq, le_lt, le_eq;

   // MSB-first magnitude compare carried out across all lanes in parallel
   always_comb begin
      ge_gt = '0;
      ge_eq = '1;
      le_lt = '0;
      le_eq = '1;
      for (int b = NPLANE - 1; b >= 0; b--) begin
         if (LO[b]) begin
            ge_eq = ge_eq & planes[b*W +: W];
         end else begin
            ge_gt = ge_gt | (ge_eq & planes[b*W +: W]);
            ge_eq = ge_eq & ~planes[b*W +: W];
         end
         if (HI[b]) begin
            le_lt = le_lt | (le_eq & ~planes[b*W +: W]);
            le_eq = le_eq & planes[b*W +: W];
         end else begin
            le_eq = le_eq & ~planes[b*W +: W];
         end
      end
      hit = (ge_gt | ge_eq) & (le_lt | le_eq);
   end
endmodule

// File: rtl/bp_class.sv
module bp_class
   import bp_pkg::*;
#(
   parameter int                  W      = 16,
   parameter int                  NRNG   = 2,
   parameter logic [NRNG*8-1:0]   LO_VEC = '0,
   parameter logic [NRNG*8-1:0]   HI_VEC = '0,
   parameter bit                  NEG    = 1'b0,
   parameter bit                  ANY    = 1'b0
) (
   input  logic [NPLANE*W-1:0] planes,
   output logic [W-1:0]        cls
);
   if (NRNG < 1) begin : g_bad_rng
      $error("bp_class: NRNG must be at least 1");
   end

   if (ANY) begin : g_any
      logic [W-1:0] is_nl;
      bp_range_match #(.W(W), .LO(NEWLINE), .HI(NEWLINE)) u_nl (
         .planes(planes),
         .hit   (is_nl)
      );
      assign cls = ~is_nl;
   end else begin : g_ranges
      logic [W-1:0] hits [NRNG];
      logic [W-1:0] any_hit;
      for (genvar r = 0; r < NRNG; r++) begin : g_rng
         bp_range_match #(
            .W (W),
            .LO(LO_VEC[r*8 +: 8]),
            .HI(HI_VEC[r*8 +: 8])
         ) u_rng (
            .planes(planes),
            .hit   (hits[r])
         );
      end
      always_comb begin
         any_hit = '0;
         for (int r = 0; r < NRNG; r++) any_hit = any_hit | hits[r];
      end
      if (NEG) begin : g_neg
         assign cls = ~any_hit;
      end else begin : g_pos
         assign cls = any_hit;
      end
   end
endmodule

// File: rtl/byteplane_classifier.sv
module byteplane_classifier
   import bp_pkg::*;
#(
   parameter int                       W      = 16,
   parameter int                       NCLS   = 4,
   parameter int                       NRNG   = 2,
   parameter logic [NCLS*NRNG*8-1:0]   CLS_LO = 64'h0000_FF30_6141_5F30,
   parameter logic [NCLS*NRNG*8-1:0]   CLS_HI = 64'h0000_0039_7A5A_5F39,
   parameter logic [NCLS-1:0]          CLS_NEG = 4'b0100,
   parameter logic [NCLS-1:0]          CLS_ANY = 4'b1000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [W*8-1:0]        in_data,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [8*W-1:0]        out_planes,
   output logic [NCLS*W-1:0]     out_class
);
   localparam int RW = NCLS * NRNG * 8;

   if (W < 1 || NCLS < 1 || NRNG < 1) begin : g_bad_cfg
      $error("byteplane_classifier: W, NCLS and NRNG must be positive");
   end

   logic [NPLANE*W-1:0] planes_c;
   logic [NCLS*W-1:0]   class_c;
   logic                take;

   bp_transpose #(.W(W)) u_xpose (
      .blk   (in_data),
      .planes(planes_c)
   );

   for (genvar c = 0; c < NCLS; c++) begin : g_cls
      bp_class #(
         .W     (W),
         .NRNG  (NRNG),
         .LO_VEC(CLS_LO[c*NRNG*8 +: NRNG*8]),
         .HI_VEC(CLS_HI[c*NRNG*8 +: NRNG*8]),
         .NEG   (CLS_NEG[c]),
         .ANY   (CLS_ANY[c])
      ) u_cls (
         .planes(planes_c),
         .cls   (class_c[c*W +: W])
      );
   end

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_planes <= '0;
         out_class  <= '0;
      end else begin
         if (take) begin
            out_valid  <= 1'b1;
            out_planes <= planes_c;
            out_class  <= class_c;
         end else if (out_ready) begin
            out_valid  <= 1'b0;
         end
      end
   end

   // R5
   accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_planes) && $stable(out_class));

   // R7
   drain_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !in_valid |=> !out_valid);

   // R1
   for (genvar b = 0; b < NPLANE; b++) begin : g_lane0_chk
      lane0_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && in_ready |=> out_planes[b*W] == $past(in_data[b]));
   end

   for (genvar c = 0; c < NCLS; c++) begin : g_any_chk
      if (CLS_ANY[c]) begin : g_on
         for (genvar j = 0; j < W; j++) begin : g_lane
            byte_t lane_byte;
            always_comb begin
               for (int b = 0; b < NPLANE; b++) lane_byte[b] = out_planes[b*W+j];
            end
            // R4
            any_newline_chk: assert property (@(posedge clk) disable iff (!rst_n)
               out_valid |-> out_class[c*W+j] == (lane_byte != NEWLINE));
         end
      end
   end

   logic unused_rw;
   assign unused_rw = (RW == 0);
endmodule

// File: tb/byteplane_classifier_tb.sv
module byteplane_classifier_tb;
   localparam int W = 16;
   localparam int NCLS = 4;
   localparam int NRNG = 2;
   localparam logic [NCLS*NRNG*8-1:0] LO = 64'h0000_FF30_6141_5F30;
   localparam logic [NCLS*NRNG*8-1:0] HI = 64'h0000_0039_7A5A_5F39;
   localparam logic [NCLS-1:0] NEG = 4'b0100;
   localparam logic [NCLS-1:0] ANY = 4'b1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [W*8-1:0] in_data = '0;
   logic out_valid;
   logic out_ready = 1'b1;
   logic [8*W-1:0] out_planes;
   logic [NCLS*W-1:0] out_class;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   byteplane_classifier #(
      .W(W), .NCLS(NCLS), .NRNG(NRNG),
      .CLS_LO(LO), .CLS_HI(HI), .CLS_NEG(NEG), .CLS_ANY(ANY)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_planes(out_planes), .out_class(out_class)
   );

   function automatic bit member(input int c, input logic [7:0] v);
      bit h = 1'b0;
      if (ANY[c]) return v != 8'h0A;
      for (int r = 0; r < NRNG; r++) begin
         int lo = LO[(c*NRNG+r)*8 +: 8];
         int hi = HI[(c*NRNG+r)*8 +: 8];
         if (int'(v) >= lo && int'(v) <= hi) h = 1'b1;
      end
      return NEG[c] ? !h : h;
   endfunction

   task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_block(input logic [W*8-1:0] d);
      logic [8*W-1:0] ep;
      logic [W-1:0] ec;
      for (int j = 0; j < W; j++)
         for (int b = 0; b < 8; b++) ep[b*W+j] = d[j*8+b];
      check("R5 out_valid after accept", 256'(out_valid), 256'(1));
      check("R1 planes", 256'(out_planes), 256'(ep));
      for (int c = 0; c < NCLS; c++) begin
         for (int j = 0; j < W; j++) ec[j] = member(c, d[j*8 +: 8]);
         if (ANY[c]) check("R4 any-char class", 256'(out_class[c*W +: W]), 256'(ec));
         else if (NEG[c]) check("R3 negated class", 256'(out_class[c*W +: W]), 256'(ec));
         else check("R2 range class", 256'(out_class[c*W +: W]), 256'(ec));
      end
   endtask

   task automatic xfer(input logic [W*8-1:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_data = d;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_block(d);
   endtask

   initial begin
      logic [W*8-1:0] d;
      logic [W*8-1:0] a;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8
      check("R8 out_valid after reset", 256'(out_valid), 256'(0));
      check("R8 in_ready after reset", 256'(in_ready), 256'(1));

      // exhaustive sweep of all byte values across all classes (R1..R4)
      for (int k = 0; k < 256 / W; k++) begin
         for (int j = 0; j < W; j++) d[j*8 +: 8] = 8'(k*W + j);
         xfer(d);
      end
      // R7: taken with nothing new accepted
      @(negedge clk);
      check("R7 out_valid drops", 256'(out_valid), 256'(0));

      // random blocks with frequent newlines and boundary bytes
      for (int n = 0; n < 40; n++) begin
         for (int j = 0; j < W; j++) begin
            case ($urandom % 6)
               0: d[j*8 +: 8] = 8'h0A;
               1: d[j*8 +: 8] = 8'h2F + 8'($urandom % 3);
               2: d[j*8 +: 8] = 8'h39 + 8'($urandom % 2);
               default: d[j*8 +: 8] = 8'($urandom);
            endcase
         end
         xfer(d);
      end

      // R6: stall holds output and blocks new input
      for (int j = 0; j < W; j++) a[j*8 +: 8] = 8'(8'h30 + j);
      for (int j = 0; j < W; j++) d[j*8 +: 8] = 8'h0A;
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1;
      in_data = a;
      @(negedge clk);
      in_data = d;
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         check("R6 in_ready low in stall", 256'(in_ready), 256'(0));
         check_block(a);
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_block(d);
      @(negedge clk);
      check("R7 out_valid drops after stall", 256'(out_valid), 256'(0));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule